// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block is a sequential arithmetic unit for a 16-bit datapath. From one start pulse it computes either a 16x16 product or a 32-by-16 quotient and remainder, signed or unsigned. Two 16-bit result registers, a low word and a high word, hold the outcome.

The multiplier recodes four multiplier bits per cycle with a radix-16 Booth digit. The divider is a restoring divider that settles two quotient bits per cycle. Each operation spends one extra cycle preparing operands, and its final iteration cycle also applies the sign correction.

A caller drives a one-cycle start together with the operation kind, the signedness and the operands. It then waits for the done pulse. A pending interrupt can raise the abort input to drop the operation part way through. After an abort the unit is immediately free for new work.

Top module: `muldiv_iter`

## Requirements
- R1: After reset, busy_o, done_o and err_o are low and both result registers read zero.
- R2: A multiply accepted at clock edge E0 holds busy_o high after edges E0 to E4 and pulses done_o for exactly one cycle after edge E5, with busy_o low in that cycle.
- R3: A divide accepted at edge E0 holds busy_o high after edges E0 to E9 and pulses done_o for one cycle after edge E10.
- R4: A multiply (op_div_i=0) takes the low 16 bits of src_a_i times src_b_i, as two's complement when signed_i=1 and unsigned otherwise. res_hi_o:res_lo_o then hold the 32-bit product, high half in res_hi_o.
- R5: A divide (op_div_i=1) divides the 32-bit src_a_i by the 16-bit src_b_i. The quotient goes to res_lo_o and the remainder to res_hi_o. In signed mode the quotient truncates toward zero and a nonzero remainder carries the dividend's sign.
- R6: A divide by zero raises err_o in the done cycle and leaves both result registers unchanged.
- R7: A divide whose quotient does not fit 16 bits raises err_o in the done cycle and leaves both result registers unchanged. In unsigned mode that means a quotient above 65535. In signed mode it means a quotient outside -32768 to 32767.
- R8: abort_i high at an edge while busy_o is high clears busy_o after that edge. No done_o pulse follows, and the result registers keep their contents.
- R9: start_i is ignored while busy_o is high, so the running operation completes with its original operands. abort_i has no effect while idle.
- R10: done_o and busy_o are never high together, err_o is only high with done_o, and the result registers change only in a done cycle without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_div_i | input | 1 | 1 = divide, 0 = multiply |
| signed_i | input | 1 | 1 = two's complement operands |
| abort_i | input | 1 | Cancels the running operation |
| src_a_i | input | 32 | Dividend; low 16 bits are the multiplicand |
| src_b_i | input | 16 | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Divide error, valid with done_o |
| res_lo_o | output | 16 | Low product word or quotient |
| res_hi_o | output | 16 | High product word or remainder |

## Verification
The embedded assertions check several properties on every cycle:
- done and busy are mutually exclusive, and an error never appears without done.
- The result registers stay frozen outside a successful done.
- An abort takes effect after a single edge.
- A start seen while busy never reopens the setup phase.
- The done pulse sits exactly five or ten edges after the accepting edge.
- A zero divisor always ends in an error.

The arithmetic itself can only be shown by the bench's scenarios, against a behavioural model built on integer arithmetic. These cover both signs, the most negative operands, quotients that just fit or just overflow, aborts at several depths, and starts issued into a running operation.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int unsigned WORD      = 16;
  localparam int unsigned MUL_DIGIT = 4;
  localparam int unsigned DIV_DIGIT = 2;
  localparam int unsigned MUL_ITERS = WORD / MUL_DIGIT;
  localparam int unsigned DIV_ITERS = (WORD + DIV_DIGIT) / DIV_DIGIT;
  localparam int unsigned QBITS     = DIV_ITERS * DIV_DIGIT;
  localparam int unsigned CNT_W     = $clog2(DIV_ITERS + 1);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;
endpackage

// File: rtl/muldiv_booth_step.sv
module muldiv_booth_step #(
  parameter int unsigned W   = 16,
  parameter int unsigned DIG = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [W:0]       mcand_i,
  input  logic [DIG-1:0]   bits_i,
  input  logic             prev_i,
  input  logic             top_unsigned_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [2*W-1:0]   addend_o
);
  localparam int unsigned DW = DIG + 2;
  localparam int unsigned PW = DW + W + 1;

  logic signed [DW-1:0] digit;
  logic signed [PW-1:0] prod;
  logic        [2*W-1:0] ext;

  always_comb begin
    digit = $signed({2'b00, bits_i}) + $signed({{(DW-1){1'b0}}, prev_i});
    if (!top_unsigned_i && bits_i[DIG-1])
      digit = digit - $signed(DW'(1 << DIG));
    prod     = digit * $signed(mcand_i);
    ext      = {{(2*W-PW){prod[PW-1]}}, prod};
    addend_o = ext << (idx_i * DIG);
  end
endmodule

// File: rtl/muldiv_div_step.sv
module muldiv_div_step #(
  parameter int unsigned W    = 16,
  parameter int unsigned BITS = 2
) (
  input  logic [W-1:0]    rem_i,
  input  logic [W-1:0]    dvs_i,
  input  logic [BITS-1:0] din_i,
  output logic [W-1:0]    rem_o,
  output logic [BITS-1:0] q_o
);
  logic [W-1:0] chain [BITS+1];

  assign chain[0] = rem_i;

  for (genvar i = 0; i < BITS; i++) begin : g_stage
    logic [W:0] trial;
    logic [W:0] diff;
    assign trial = {chain[i], din_i[BITS-1-i]};
    assign diff  = trial - {1'b0, dvs_i};
    assign q_o[BITS-1-i] = ~diff[W];
    assign chain[i+1]    = diff[W] ? trial[W-1:0] : diff[W-1:0];
  end

  assign rem_o = chain[BITS];
endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter
  import muldiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        op_div_i,
  input  logic        signed_i,
  input  logic        abort_i,
  input  logic [31:0] src_a_i,
  input  logic [15:0] src_b_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] res_lo_o,
  output logic [15:0] res_hi_o
);
  localparam int unsigned IDX_W = $clog2(MUL_ITERS);
  localparam int unsigned HIGH  = 2*WORD - QBITS;

  // reset synchronizer: asserts at once, releases on the second edge
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  phase_t             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               is_div_q, is_sgn_q;
  logic [2*WORD-1:0]  a_q;
  logic [WORD-1:0]    b_q;
  logic [WORD:0]      mcand_q;
  logic [WORD-1:0]    mplr_q;
  logic               prev_q;
  logic [2*WORD-1:0]  acc_q;
  logic [WORD-1:0]    rem_q, dvs_q;
  logic [QBITS-1:0]   dsh_q, quo_q;
  logic               qneg_q, rneg_q, early_err_q;
  logic               done_q, err_q;
  logic [WORD-1:0]    lo_q, hi_q;

  logic accept, setup_en, run_en, fin, res_en, done_d, err_d;
  logic [CNT_W-1:0] last_idx;

  // operand preparation for the setup cycle
  logic [2*WORD-1:0] a_mag;
  logic [WORD-1:0]   b_mag;
  logic              early_err;
  always_comb begin
    a_mag     = (is_sgn_q && a_q[2*WORD-1]) ? -a_q : a_q;
    b_mag     = (is_sgn_q && b_q[WORD-1])   ? -b_q : b_q;
    early_err = (b_q == '0) ||
                ({{(WORD-HIGH){1'b0}}, a_mag[2*WORD-1 -: HIGH]} >= b_mag);
  end

  // iteration datapath
  logic [2*WORD-1:0]    addend, acc_nxt;
  logic [WORD-1:0]      rem_nxt;
  logic [DIV_DIGIT-1:0] qdig;
  logic [QBITS-1:0]     quo_nxt;

  muldiv_booth_step #(.W(WORD), .DIG(MUL_DIGIT), .IDX_W(IDX_W)) u_booth (
    .mcand_i        (mcand_q),
    .bits_i         (mplr_q[MUL_DIGIT-1:0]),
    .prev_i         (prev_q),
    .top_unsigned_i (!is_sgn_q && (cnt_q == CNT_W'(MUL_ITERS-1))),
    .idx_i          (cnt_q[IDX_W-1:0]),
    .addend_o       (addend)
  );

  muldiv_div_step #(.W(WORD), .BITS(DIV_DIGIT)) u_dstep (
    .rem_i (rem_q),
    .dvs_i (dvs_q),
    .din_i (dsh_q[QBITS-1 -: DIV_DIGIT]),
    .rem_o (rem_nxt),
    .q_o   (qdig)
  );

  assign acc_nxt = acc_q + addend;
  assign quo_nxt = {quo_q[QBITS-DIV_DIGIT-1:0], qdig};

  // result adjust
  logic            late_err;
  logic [WORD-1:0] lo_fin, hi_fin;
  always_comb begin
    if (!is_sgn_q)
      late_err = |quo_nxt[QBITS-1:WORD];
    else if (qneg_q)
      late_err = quo_nxt > QBITS'(1 << (WORD-1));
    else
      late_err = quo_nxt > QBITS'((1 << (WORD-1)) - 1);
    if (is_div_q) begin
      lo_fin = qneg_q ? -quo_nxt[WORD-1:0] : quo_nxt[WORD-1:0];
      hi_fin = rneg_q ? -rem_nxt : rem_nxt;
    end else begin
      lo_fin = acc_nxt[WORD-1:0];
      hi_fin = acc_nxt[2*WORD-1:WORD];
    end
  end

  // sequencer next state
  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    last_idx = is_div_q ? CNT_W'(DIV_ITERS-1) : CNT_W'(MUL_ITERS-1);
    accept   = (phase_q == PH_IDLE) && start_i;
    setup_en = (phase_q == PH_SETUP) && !abort_i;
    run_en   = (phase_q == PH_RUN) && !abort_i;
    fin      = run_en && (cnt_q == last_idx);
    err_d    = fin && is_div_q && (early_err_q || late_err);
    res_en   = fin && !err_d;
    done_d   = fin;
    if (phase_q != PH_IDLE && abort_i) begin
      phase_d = PH_IDLE;
    end else if (accept) begin
      phase_d = PH_SETUP;
    end else if (setup_en) begin
      phase_d = PH_RUN;
      cnt_d   = '0;
    end else if (fin) begin
      phase_d = PH_IDLE;
    end else if (run_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      is_div_q <= 1'b0;
      is_sgn_q <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
    end else if (accept) begin
      is_div_q <= op_div_i;
      is_sgn_q <= signed_i;
      a_q      <= src_a_i;
      b_q      <= src_b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mcand_q     <= '0;
      mplr_q      <= '0;
      prev_q      <= 1'b0;
      acc_q       <= '0;
      rem_q       <= '0;
      dvs_q       <= '0;
      dsh_q       <= '0;
      quo_q       <= '0;
      qneg_q      <= 1'b0;
      rneg_q      <= 1'b0;
      early_err_q <= 1'b0;
    end else if (setup_en) begin
      mcand_q     <= {is_sgn_q & a_q[WORD-1], a_q[WORD-1:0]};
      mplr_q      <= b_q;
      prev_q      <= 1'b0;
      acc_q       <= '0;
      rem_q       <= {{(WORD-HIGH){1'b0}}, a_mag[2*WORD-1 -: HIGH]};
      dvs_q       <= b_mag;
      dsh_q       <= a_mag[QBITS-1:0];
      quo_q       <= '0;
      qneg_q      <= is_sgn_q && (a_q[2*WORD-1] ^ b_q[WORD-1]);
      rneg_q      <= is_sgn_q && a_q[2*WORD-1];
      early_err_q <= early_err;
    end else if (run_en) begin
      mplr_q <= mplr_q >> MUL_DIGIT;
      prev_q <= mplr_q[MUL_DIGIT-1];
      acc_q  <= acc_nxt;
      rem_q  <= rem_nxt;
      dsh_q  <= dsh_q << DIV_DIGIT;
      quo_q  <= quo_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (res_en) begin
      lo_q <= lo_fin;
      hi_q <= hi_fin;
    end
  end

  assign busy_o   = (phase_q != PH_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign res_lo_o = lo_q;
  assign res_hi_o = hi_q;

  // R10
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |-> !busy_o);
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_o |-> done_o);
  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!done_o || err_o) |-> $stable({res_hi_o, res_lo_o}));
  // R8
  abort_cancel_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy_o && abort_i) |=> (!busy_o && !done_o));
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy_o && start_i) |=> (phase_q != PH_SETUP));
  // R2
  mul_latency_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done_o && !is_div_q) |-> ($past(busy_o, 5) && !$past(busy_o, 6)));
  // R3
  div_latency_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done_o && is_div_q) |-> ($past(busy_o, 10) && !$past(busy_o, 11)));
  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done_o && is_div_q && (b_q == '0)) |-> err_o);
endmodule

// File: tb/muldiv_iter_bench.sv
module muldiv_iter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, op_div_i, signed_i, abort_i;
  logic [31:0] src_a_i;
  logic [15:0] src_b_i;
  logic        busy_o, done_o, err_o;
  logic [15:0] res_lo_o, res_hi_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit chk_en = 1'b0;

  always #5 clk = ~clk;

  muldiv_iter u_muldiv_iter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_div_i(op_div_i),
    .signed_i(signed_i), .abort_i(abort_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .res_lo_o(res_lo_o), .res_hi_o(res_hi_o)
  );

  // behavioural reference model
  bit          m_busy, m_done, m_err, p_err;
  int          m_left;
  logic [15:0] m_lo, m_hi, p_lo, p_hi;
  string       t_tag = "R2";
  string       r_tag = "R4";

  task automatic calc(input bit dv, input bit sg, input logic [31:0] a,
                      input logic [15:0] b, output bit e,
                      output logic [15:0] lo, output logic [15:0] hi);
    longint x, y, q, r, p;
    e = 1'b0; lo = 16'h0; hi = 16'h0;
    if (!dv) begin
      x = sg ? longint'($signed(a[15:0])) : longint'(a[15:0]);
      y = sg ? longint'($signed(b)) : longint'(b);
      p = x * y;
      lo = p[15:0]; hi = p[31:16];
    end else begin
      x = sg ? longint'($signed(a)) : longint'(a);
      y = sg ? longint'($signed(b)) : longint'(b);
      if (y == 0) e = 1'b1;
      else begin
        q = x / y; r = x % y;
        if (sg ? (q > 32767 || q < -32768) : (q > 65535)) e = 1'b1;
        lo = q[15:0]; hi = r[15:0];
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_left = 0; m_lo = 0; m_hi = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (m_busy) begin
        if (abort_i) begin
          m_busy = 0; t_tag = "R8"; r_tag = "R8";
        end else begin
          m_left--;
          if (m_left == 0) begin
            m_busy = 0; m_done = 1; m_err = p_err;
            if (!p_err) begin m_lo = p_lo; m_hi = p_hi; end
          end
        end
      end else if (start_i) begin
        m_busy = 1;
        m_left = op_div_i ? 10 : 5;
        t_tag  = op_div_i ? "R3" : "R2";
        calc(op_div_i, signed_i, src_a_i, src_b_i, p_err, p_lo, p_hi);
        if (!op_div_i) r_tag = "R4";
        else if (src_b_i == 0) r_tag = "R6";
        else if (p_err) r_tag = "R7";
        else r_tag = "R5";
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check(busy_o == m_busy, t_tag, "busy", 32'(busy_o), 32'(m_busy));
      check(done_o == m_done, t_tag, "done", 32'(done_o), 32'(m_done));
      check(err_o == m_err, r_tag, "err", 32'(err_o), 32'(m_err));
      check({res_hi_o, res_lo_o} == {m_hi, m_lo}, r_tag, "result",
            {res_hi_o, res_lo_o}, {m_hi, m_lo});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic issue(input bit dv, input bit sg, input logic [31:0] a,
                       input logic [15:0] b);
    start_i = 1; op_div_i = dv; signed_i = sg; src_a_i = a; src_b_i = b;
    tick();
    start_i = 0;
  endtask

  task automatic run(input bit dv, input bit sg, input logic [31:0] a,
                     input logic [15:0] b);
    issue(dv, sg, a, b);
    tick(dv ? 10 : 5);
  endtask

  initial begin
    rst_n = 0; start_i = 0; op_div_i = 0; signed_i = 0; abort_i = 0;
    src_a_i = 0; src_b_i = 0;
    tick(3);
    rst_n = 1;
    tick(3);
    @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o && !err_o, "R1", "flags",
          {29'b0, busy_o, done_o, err_o}, 32'h0);
    check({res_hi_o, res_lo_o} == 32'h0, "R1", "result",
          {res_hi_o, res_lo_o}, 32'h0);
    chk_en = 1;
    tick();

    // R4 multiply patterns
    run(0, 0, 32'h0000_FFFF, 16'hFFFF);
    run(0, 1, 32'h0000_FFFF, 16'hFFFF);
    run(0, 1, 32'h0000_8000, 16'h8000);
    run(0, 1, 32'h0000_1234, 16'hFFF3);
    run(0, 0, 32'h0000_8000, 16'h8421);
    run(0, 1, 32'h0000_7FFF, 16'h8000);
    // R5 divide patterns
    run(1, 0, 32'h0012_3456, 16'h0100);
    run(1, 1, 32'hFFFF_FF85, 16'h0007);   // -123 / 7
    run(1, 1, 32'h0000_007B, 16'hFFF9);   // 123 / -7
    run(1, 1, 32'hFFFF_0000, 16'h0002);   // quotient -32768 fits
    run(1, 0, 32'hFFFE_FFFF, 16'hFFFF);   // quotient 65535 fits
    // R6 zero divisor
    run(1, 0, 32'h0000_0055, 16'h0000);
    run(1, 1, 32'h8000_0000, 16'h0000);
    // R7 overflow
    run(1, 0, 32'h0001_0000, 16'h0001);
    run(1, 1, 32'h8000_0000, 16'hFFFF);
    run(1, 1, 32'h0001_0000, 16'h0002);   // +32768 overflows
    run(1, 0, 32'hFFFF_FFFF, 16'h0003);

    // R8 abort at several depths
    for (int d = 0; d < 10; d++) begin
      issue(d[0], 1, 32'h0BAD_CAFE, 16'h0101);
      tick(d);
      abort_i = 1; tick(); abort_i = 0;
      @(negedge clk);
      check(!busy_o, "R8", "busy after abort", 32'(busy_o), 32'h0);
      tick(12);
      check(!done_o, "R8", "no done", 32'(done_o), 32'h0);
    end

    // R9 start while busy ignored, abort while idle ignored
    issue(1, 0, 32'h0000_0064, 16'h0007);
    tick(2);
    issue(0, 0, 32'h0000_0003, 16'h0003);
    tick(7);
    @(negedge clk);
    check(done_o && res_lo_o == 16'd14 && res_hi_o == 16'd2, "R9",
          "first op kept", {res_hi_o, res_lo_o}, {16'd2, 16'd14});
    tick();
    abort_i = 1; tick(2);
    issue(0, 0, 32'h0000_0010, 16'h0010);
    abort_i = 0;
    tick(5);
    @(negedge clk);
    check(res_lo_o == 16'h0100, "R9", "idle abort", 32'(res_lo_o), 32'h100);
    tick();

    // back-to-back and random mix
    for (int k = 0; k < 300; k++) begin
      logic [31:0] ra;
      logic [15:0] rb;
      ra = $urandom;
      rb = $urandom;
      if (k % 3 == 0) ra = ra >> (k % 17);
      if (k % 5 == 0) rb = rb >> 12;
      run(k[0], k[1], ra, rb);
    end

    tick(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule